// File: doc/BRIEF.md
# Fast-Page DRAM Access Controller

This controller sits between a single-request CPU-side bus and an asynchronous DRAM. It splits a linear byte address into a row phase and a column phase on a shared multiplexed address bus, and it drives the active-low row strobe, column strobe and write strobe. The row and column split is set by a 2-bit shift code. Data is not touched: write data is forwarded to the memory and read data is forwarded back to the requester.

A requester raises `req_i` with a stable address, write flag and DRAM-space qualifier. It keeps them stable until `ack_o` pulses for one cycle. Four static configuration inputs shape each transaction:
- the precharge length (one or two states);
- whether same-row accesses may reuse the open row as fast-page column cycles;
- whether the row strobe stays low while the controller is idle, so that the row stays open;
- the shift code.

The shift code sets both how the row is taken from the address and which upper address bits are compared to detect a page hit. An access outside DRAM space closes any open row and completes without any strobe activity.

Top module: `fpdram_ctrl`

## Requirements
- R1: After reset, `ras_n_o`, `cas_n_o` and `we_n_o` are high and `ack_o` is low.
- R2: A full access, with the precharge code at 0, runs in order: one state with `ras_n_o` high, one row state (`ras_n_o` low, `cas_n_o` high, `ma_o` = row), and one column state (`cas_n_o` low, `ma_o` = column) in which `ack_o` is high. `ack_o` is seen 3 cycles after the request is accepted, and it is never high for two cycles in a row.
- R3: With `cfg_pre2_i` = 1, a full access holds `ras_n_o` high for two states before the row state, and `ack_o` is seen 4 cycles after acceptance.
- R4: Shift code n (0..3) gives a shift S = 8 + n. The row is `addr_i >> S` truncated to the width of `ma_o`, and the column is `addr_i[S-1:0]` zero-extended.
- R5: With `cfg_burst_i` = 0, an access to the row that is already open is still a full access (3 cycles at precharge code 0).
- R6: With `cfg_burst_i` = 1 and an open row equal to `addr_i[AW-1:S]`, the access goes straight to the column state. `ack_o` is seen 1 cycle after acceptance, with no precharge and no row state, and `ras_n_o` stays low throughout. `cas_n_o` is high in the idle state before it.
- R7: The page-hit comparison uses only address bits at and above S. Addresses that differ in bit 9 miss when S = 8, and they hit when S = 10.
- R8: With `cfg_rasdown_i` = 0, an idle cycle in which no request is present drives `ras_n_o` high on the next cycle, and it closes the row. A request that arrives in the first idle cycle after `ack_o` can still hit.
- R9: With `cfg_rasdown_i` = 1, `ras_n_o` stays low through idle cycles of any length while a row is open. A same-row access after the gap is a page hit.
- R10: With `cfg_rasdown_i` = 1, a DRAM access to a different row first drives `ras_n_o` high for the full precharge and then opens the new row.
- R11: A request with `dram_space_i` = 0 is acknowledged 1 cycle after acceptance, with `ras_n_o` and `cas_n_o` high. It closes any open row, so the next DRAM access is a full one.
- R12: `we_n_o` is low only in the column state of a write. `mem_wdata_o` follows `wdata_i`, and `rdata_o` follows `mem_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (20) | Linear access address |
| dram_space_i | input | 1 | Access targets DRAM space |
| wdata_i | input | DW (16) | Write data from requester |
| rdata_o | output | DW (16) | Read data to requester |
| ack_o | output | 1 | One-cycle completion pulse |
| cfg_pre2_i | input | 1 | 0 = one precharge state, 1 = two |
| cfg_burst_i | input | 1 | Enable fast-page same-row accesses |
| cfg_rasdown_i | input | 1 | Keep row open while idle |
| cfg_shift_i | input | 2 | Row shift code, S = 8 + code |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| ma_o | output | MAW (12) | Multiplexed row/column address |
| mem_wdata_o | output | DW (16) | Write data to memory |
| mem_rdata_i | input | DW (16) | Read data from memory |

## Verification
The embedded properties watch the strobe rules on every cycle. A column strobe needs the row strobe low, the write strobe is low only inside a column cycle, and the acknowledge is never held. A row state is always preceded by the configured number of RAS-high states, and a direct page cycle never follows a closed row. The idle behaviour follows the hold mode, and a non-DRAM completion keeps both strobes high. Only the directed scenarios can show the address values on the multiplexed bus for each shift code, the exact latencies, and the decision between hit and miss. That decision depends on the history of open rows, the burst setting and the shift-dependent comparison width.

// File: rtl/fpdram_pkg.sv
package fpdram_pkg;
  // smallest row shift; code n selects BASE_SHIFT + n
  localparam int unsigned BASE_SHIFT = 8;
  localparam int unsigned NUM_SHIFT  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL,
    ST_NACK
  } seq_state_e;
endpackage

// File: rtl/fpdram_addr_map.sv
module fpdram_addr_map
  import fpdram_pkg::*;
#(
  parameter int unsigned AW  = 20,
  parameter int unsigned MAW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr_i,
  input  logic [1:0]     shift_i,
  input  logic           load_i,
  output logic [MAW-1:0] row_ma_o,
  output logic [MAW-1:0] col_ma_o,
  output logic           hit_o
);
  // only bits at or above the smallest shift ever take part in a compare
  logic [AW-1:BASE_SHIFT] open_q, open_d;

  logic [MAW-1:0]       row_c [NUM_SHIFT];
  logic [MAW-1:0]       col_c [NUM_SHIFT];
  logic [NUM_SHIFT-1:0] hit_c;

  for (genvar g = 0; g < NUM_SHIFT; g++) begin : g_shift
    localparam int unsigned SH = BASE_SHIFT + g;
    assign row_c[g] = MAW'(addr_i >> SH);
    assign col_c[g] = MAW'(addr_i[SH-1:0]);
    assign hit_c[g] = (addr_i[AW-1:SH] == open_q[AW-1:SH]);
  end

  assign row_ma_o = row_c[shift_i];
  assign col_ma_o = col_c[shift_i];
  assign hit_o    = hit_c[shift_i];

  always_comb begin
    open_d = open_q;
    if (load_i) open_d = addr_i[AW-1:BASE_SHIFT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else        open_q <= open_d;
  end
endmodule

// File: rtl/fpdram_seq.sv
module fpdram_seq
  import fpdram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic dram_i,
  input  logic we_i,
  input  logic cfg_pre2_i,
  input  logic cfg_burst_i,
  input  logic cfg_rasdown_i,
  input  logic hit_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic ack_o,
  output logic load_o,
  output logic sel_row_o
);
  localparam int unsigned PCW = 1;  // precharge extra-state counter width

  seq_state_e     state_q, state_d;
  logic           open_q, open_d;
  logic [PCW-1:0] pre_q, pre_d;

  always_comb begin
    state_d = state_q;
    open_d  = open_q;
    pre_d   = pre_q;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (!dram_i) begin
            state_d = ST_NACK;
            open_d  = 1'b0;
          end else if (open_q && cfg_burst_i && hit_i) begin
            state_d = ST_COL;
          end else begin
            state_d = ST_PRE;
            open_d  = 1'b0;
            pre_d   = PCW'(cfg_pre2_i);
          end
        end else if (!cfg_rasdown_i) begin
          open_d = 1'b0;
        end
      end
      ST_PRE: begin
        if (pre_q != '0) begin
          pre_d = pre_q - 1'b1;
        end else begin
          state_d = ST_ROW;
          open_d  = 1'b1;
          load_o  = 1'b1;
        end
      end
      ST_ROW:  state_d = ST_COL;
      ST_COL:  state_d = ST_IDLE;
      ST_NACK: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      open_q  <= 1'b0;
      pre_q   <= '0;
    end else begin
      state_q <= state_d;
      open_q  <= open_d;
      pre_q   <= pre_d;
    end
  end

  assign ras_n_o   = !open_q;
  assign cas_n_o   = (state_q != ST_COL);
  assign we_n_o    = !((state_q == ST_COL) && we_i);
  assign ack_o     = (state_q == ST_COL) || (state_q == ST_NACK);
  assign sel_row_o = (state_q == ST_PRE) || (state_q == ST_ROW);

  // R2: column strobe only inside an open row
  p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_o |-> !ras_n_o);
  // R2: acknowledge is a single-cycle pulse
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  // R3: a row state follows at least one RAS-high state
  p_pre_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROW) |-> $past(ras_n_o));
  // R3: two RAS-high states when configured
  p_pre_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROW && cfg_pre2_i) |-> ($past(ras_n_o) && $past(ras_n_o, 2)));
  // R6: a direct page cycle never starts from a closed row
  p_hit_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COL && $past(state_q) == ST_IDLE) |-> !$past(ras_n_o));
  // R8: idle without request in RAS-up mode closes the row
  p_idle_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !req_i && !cfg_rasdown_i) |=> ras_n_o);
  // R9: idle without request in RAS-down mode keeps an open row
  p_idle_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !req_i && cfg_rasdown_i && !ras_n_o) |=> !ras_n_o);
  // R11: non-DRAM completion without strobes
  p_nack_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NACK) |-> (ras_n_o && cas_n_o));
  // R12: write strobe only with column strobe
  p_we_in_col_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> !cas_n_o);
endmodule

// File: rtl/fpdram_ctrl.sv
module fpdram_ctrl
  import fpdram_pkg::*;
#(
  parameter int unsigned AW  = 20,
  parameter int unsigned MAW = 12,
  parameter int unsigned DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           dram_space_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           ack_o,
  input  logic           cfg_pre2_i,
  input  logic           cfg_burst_i,
  input  logic           cfg_rasdown_i,
  input  logic [1:0]     cfg_shift_i,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [MAW-1:0] ma_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  localparam int unsigned RSYNC = 2;

  // asynchronous assert, synchronous release
  logic [RSYNC-1:0] rsync_q;
  logic             rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RSYNC-2:0], 1'b1};
  end
  assign rst_n_s = rsync_q[RSYNC-1];

  logic           load, hit, sel_row;
  logic [MAW-1:0] row_ma, col_ma;

  fpdram_addr_map #(.AW(AW), .MAW(MAW)) u_map (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .addr_i   (addr_i),
    .shift_i  (cfg_shift_i),
    .load_i   (load),
    .row_ma_o (row_ma),
    .col_ma_o (col_ma),
    .hit_o    (hit)
  );

  fpdram_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_i         (req_i),
    .dram_i        (dram_space_i),
    .we_i          (we_i),
    .cfg_pre2_i    (cfg_pre2_i),
    .cfg_burst_i   (cfg_burst_i),
    .cfg_rasdown_i (cfg_rasdown_i),
    .hit_i         (hit),
    .ras_n_o       (ras_n_o),
    .cas_n_o       (cas_n_o),
    .we_n_o        (we_n_o),
    .ack_o         (ack_o),
    .load_o        (load),
    .sel_row_o     (sel_row)
  );

  assign ma_o        = sel_row ? row_ma : col_ma;
  assign mem_wdata_o = wdata_i;
  assign rdata_o     = mem_rdata_i;
endmodule

// File: tb/fpdram_ctrl_tb_top.sv
module fpdram_ctrl_tb_top;
  localparam int AW  = 20;
  localparam int MAW = 12;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req, we, ds;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wdata, mrdata, rdata, mwdata;
  logic           ack, ras_n, cas_n, we_n;
  logic           pre2, burst, rdown;
  logic [1:0]     shift;
  logic [MAW-1:0] ma;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fpdram_ctrl #(.AW(AW), .MAW(MAW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .dram_space_i(ds), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .cfg_pre2_i(pre2), .cfg_burst_i(burst), .cfg_rasdown_i(rdown),
    .cfg_shift_i(shift), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ma_o(ma), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // results of the last access
  int             r_lat, r_pre;
  logic           r_row, r_wel, r_ras_ack, r_cas_ack;
  logic [MAW-1:0] r_rma, r_cma;

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic d);
    req = 1'b1; we = w; addr = a; ds = d;
    r_lat = 0; r_pre = 0; r_row = 1'b0; r_wel = 1'b0;
    r_rma = '0; r_cma = '0;
    while (r_lat < 20) begin
      @(negedge clk);
      r_lat++;
      if (ras_n && !r_row) r_pre++;
      if (!ras_n && cas_n) begin r_row = 1'b1; r_rma = ma; end
      if (!cas_n) begin r_cma = ma; r_wel = !we_n; end
      if (ack) break;
    end
    r_ras_ack = ras_n;
    r_cas_ack = cas_n;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "ras_n", 32'(ras_n), 1);
    check("R1", "cas_n", 32'(cas_n), 1);
    check("R1", "we_n", 32'(we_n), 1);
    check("R1", "ack", 32'(ack), 0);
  endtask

  task automatic t_full_pre1();
    access(1'b0, 20'h12345, 1'b1);
    check("R2", "latency", r_lat, 3);
    check("R2", "precharge states", r_pre, 1);
    check("R2", "row phase seen", 32'(r_row), 1);
    check("R4", "row addr S=8", 32'(r_rma), 32'h123);
    check("R4", "col addr S=8", 32'(r_cma), 32'h045);
    check("R12", "read we_n low", 32'(r_wel), 0);
    check("R12", "rdata passthrough", 32'(rdata), 32'h5A5A);
  endtask

  task automatic t_full_pre2_write();
    pre2 = 1'b1; shift = 2'd1;
    gap(1);
    access(1'b1, 20'h0ABCD, 1'b1);
    check("R3", "latency", r_lat, 4);
    check("R3", "precharge states", r_pre, 2);
    check("R4", "row addr S=9", 32'(r_rma), 32'h055);
    check("R4", "col addr S=9", 32'(r_cma), 32'h1CD);
    check("R12", "write we_n low", 32'(r_wel), 1);
    check("R12", "wdata passthrough", 32'(mwdata), 32'hA5A5);
    pre2 = 1'b0; shift = 2'd0;
  endtask

  task automatic t_burst_off();
    rdown = 1'b1; burst = 1'b0;
    gap(1);
    access(1'b0, 20'h12345, 1'b1);
    gap(1);
    access(1'b0, 20'h12377, 1'b1);
    check("R5", "same row, burst off latency", r_lat, 3);
    check("R5", "same row, burst off precharge", r_pre, 1);
    rdown = 1'b0;
  endtask

  task automatic t_page_hit_rasup();
    burst = 1'b1;
    gap(1);
    access(1'b0, 20'h20010, 1'b1);
    gap(1);
    access(1'b0, 20'h20020, 1'b1);
    check("R6", "hit latency", r_lat, 1);
    check("R6", "hit precharge", r_pre, 0);
    check("R6", "hit row phase", 32'(r_row), 0);
    check("R6", "hit col addr", 32'(r_cma), 32'h020);
    check("R8", "hit in first idle cycle, RAS low", 32'(r_ras_ack), 0);
  endtask

  task automatic t_rasup_idle();
    gap(3);
    check("R8", "RAS high after idle", 32'(ras_n), 1);
    access(1'b0, 20'h20030, 1'b1);
    check("R8", "after close latency", r_lat, 3);
  endtask

  task automatic t_shift_compare();
    rdown = 1'b1; shift = 2'd0;
    gap(1);
    access(1'b0, 20'h00000, 1'b1);
    gap(1);
    access(1'b0, 20'h00200, 1'b1);
    check("R7", "bit9 differs, S=8 miss latency", r_lat, 3);
    check("R7", "S=8 new row", 32'(r_rma), 32'h002);
    shift = 2'd2;
    gap(1);
    access(1'b0, 20'h00000, 1'b1);
    check("R7", "bit9 differs, S=10 hit latency", r_lat, 1);
    check("R7", "S=10 col addr", 32'(r_cma), 32'h000);
  endtask

  task automatic t_rasdown();
    gap(4);
    check("R9", "RAS low through idle", 32'(ras_n), 0);
    access(1'b0, 20'h00100, 1'b1);
    check("R9", "hit after gap latency", r_lat, 1);
    check("R9", "hit col addr S=10", 32'(r_cma), 32'h100);
    shift = 2'd3;
    gap(1);
    access(1'b0, 20'h7F800, 1'b1);
    check("R10", "miss latency", r_lat, 3);
    check("R10", "miss precharge", r_pre, 1);
    check("R4", "row addr S=11", 32'(r_rma), 32'h0FF);
    check("R4", "col addr S=11", 32'(r_cma), 32'h000);
  endtask

  task automatic t_non_dram();
    gap(1);
    access(1'b0, 20'h7F800, 1'b0);
    check("R11", "latency", r_lat, 1);
    check("R11", "RAS at ack", 32'(r_ras_ack), 1);
    check("R11", "CAS at ack", 32'(r_cas_ack), 1);
    gap(1);
    access(1'b0, 20'h7F800, 1'b1);
    check("R11", "row closed, next latency", r_lat, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; ds = 1'b0; addr = '0;
    wdata = 16'hA5A5; mrdata = 16'h5A5A;
    pre2 = 1'b0; burst = 1'b0; rdown = 1'b0; shift = 2'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    gap(4);
    t_reset();
    t_full_pre1();
    t_full_pre2_write();
    t_burst_off();
    t_page_hit_rasup();
    t_rasup_idle();
    t_shift_compare();
    t_rasdown();
    t_non_dram();
    gap(2);
    finish_run();
  end
endmodule